// File: doc/BRIEF.md
# Operand Forwarding Unit

This block decides, for the instruction sitting in the execute stage of a five-stage in-order integer pipeline, where each ALU operand and the ALU carry input should come from. It compares each source register number with the registers written by the two instructions ahead of it. The first is the instruction one stage ahead, whose value waits in the result register. The second is the instruction in writeback. The block then drives the select lines of the multiplexers in front of the ALU. With every path in place, dependent register-to-register instructions issue back to back and no bubble is needed.

Each producing stage can write two registers. One is its named destination. The other is a base register that autoincrement or autodecrement addressing changed as a side effect. Both count as destinations. For each operand, a separate side flag tells the datapath which of the two values of the chosen stage to take. The carry flag is handled the same way: an add-with-carry in execute takes the carry from the youngest older instruction that produced one.

The unit is purely combinational, and all of its pins are plain control levels. It has no stream traffic, so it carries no valid/ready handshake and applies no back-pressure. Write-after-read and write-after-write relations need no action in this pipeline and never select a path.

Top module: `operand_fwd_unit`

## Requirements
- R1: With no producing stage matching, each operand select is 2'b00 (register-file value), its side flag is 0, and the carry select is 2'b00.
- R2: A source equal to the named destination of the result-stage instruction, with that stage's write enable high, gives select 2'b01 and side flag 0.
- R3: A source equal to the named destination of the writeback-stage instruction, with that stage's write enable high, gives select 2'b10 and side flag 0, unless the result stage also matches.
- R4: When both stages match the same source, the result stage wins and the select is 2'b01.
- R5: Source register number 0 always gives select 2'b00 and side flag 0, whatever the stages write.
- R6: A destination whose write enable (named or side-effect) is low never causes a match.
- R7: A source equal to a stage's side-effect destination, with its side enable high, selects that stage with side flag 1. Within one stage, a named-destination match beats a side-effect match, which sets side flag 0. Across stages, the result stage still wins.
- R8: When the execute instruction reads the carry, the carry select is 2'b01 if the result stage writes the carry, otherwise 2'b10 if writeback writes it, otherwise 2'b00. When the instruction does not read the carry, the select is 2'b00.
- R9: The two operands are resolved independently of each other. Operand A is bits [4:0] of the packed source bus and operand B is bits [9:5]. The same split applies to the select bus in 2-bit slices and to the side bus in 1-bit slices.
- R10: A side flag is 1 only when its select is not 2'b00. Select value 2'b11 never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src | input | NUM_OPND*REG_AW | Source register numbers of the execute instruction, operand 0 in the low slice |
| ex_use_carry | input | 1 | Execute instruction reads the carry flag |
| rs_wr_en | input | 1 | Result-stage instruction writes its named destination |
| rs_rd | input | REG_AW | Result-stage named destination |
| rs_side_en | input | 1 | Result-stage instruction updates a base register as a side effect |
| rs_side_rd | input | REG_AW | Result-stage side-effect register |
| rs_carry_wr | input | 1 | Result-stage instruction produces a carry |
| wb_wr_en | input | 1 | Writeback instruction writes its named destination |
| wb_rd | input | REG_AW | Writeback named destination |
| wb_side_en | input | 1 | Writeback instruction updates a base register as a side effect |
| wb_side_rd | input | REG_AW | Writeback side-effect register |
| wb_carry_wr | input | 1 | Writeback instruction produces a carry |
| opnd_sel | output | NUM_OPND*2 | Per-operand multiplexer select (00 register file, 01 result, 10 writeback) |
| opnd_side | output | NUM_OPND | Per-operand: take the side-effect value of the chosen stage |
| cy_sel | output | 2 | Carry input select, same encoding |

## Verification
The hardest case to reach is one stage writing the same register through both its named destination and its side effect, while the other stage also claims that register. Random streams over the full register space almost never line up three equal register numbers. The stimulus therefore draws every register number from a pool of eight values and forces these collisions in directed cases. Carry chains are covered with both stages producing a carry, and with the carry requested and not requested, so the priority and the gating each show up at the ports.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

  // Operand source codes; the datapath multiplexers decode these values.
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_RESULT  = 2'b01,
    SRC_WRBACK  = 2'b10
  } opnd_src_e;

  // Match outcome of one source against one producing stage.
  typedef struct packed {
    logic hit_main;
    logic hit_side;
  } stage_hit_t;

endpackage

// File: rtl/stage_cmp.sv
module stage_cmp
  import opfwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] rd,
  input  logic              side_en,
  input  logic [REG_AW-1:0] side_rd,
  output stage_hit_t        hit
);

  logic src_live;

  // Register zero is hardwired and never a forwarding target.
  assign src_live = |src;

  always_comb begin
    hit.hit_main = src_live && wr_en   && (rd == src);
    hit.hit_side = src_live && side_en && (side_rd == src);
  end

endmodule

// File: rtl/opnd_pick.sv
module opnd_pick
  import opfwd_pkg::*;
(
  input  stage_hit_t near_hit,
  input  stage_hit_t far_hit,
  output opnd_src_e  sel,
  output logic       side
);

  // Youngest stage first; inside a stage the named destination first.
  always_comb begin
    sel  = SRC_REGFILE;
    side = 1'b0;
    if (near_hit.hit_main) begin
      sel = SRC_RESULT;
    end else if (near_hit.hit_side) begin
      sel  = SRC_RESULT;
      side = 1'b1;
    end else if (far_hit.hit_main) begin
      sel = SRC_WRBACK;
    end else if (far_hit.hit_side) begin
      sel  = SRC_WRBACK;
      side = 1'b1;
    end
  end

  always_comb begin
    if (near_hit.hit_main || near_hit.hit_side)
      AST_NEAR_FIRST: assert (sel == SRC_RESULT) else $error("far stage chosen over near"); // R4
  end

endmodule

// File: rtl/carry_pick.sv
module carry_pick
  import opfwd_pkg::*;
(
  input  logic      use_carry,
  input  logic      near_cy,
  input  logic      far_cy,
  output opnd_src_e sel
);

  always_comb begin
    sel = SRC_REGFILE;
    if (use_carry) begin
      if (near_cy)     sel = SRC_RESULT;
      else if (far_cy) sel = SRC_WRBACK;
    end
  end

endmodule

// File: rtl/operand_fwd_unit.sv
module operand_fwd_unit
  import opfwd_pkg::*;
#(
  parameter int REG_AW   = 5,
  parameter int NUM_OPND = 2
) (
  input  logic [NUM_OPND-1:0][REG_AW-1:0] ex_src,
  input  logic                            ex_use_carry,
  input  logic                            rs_wr_en,
  input  logic [REG_AW-1:0]               rs_rd,
  input  logic                            rs_side_en,
  input  logic [REG_AW-1:0]               rs_side_rd,
  input  logic                            rs_carry_wr,
  input  logic                            wb_wr_en,
  input  logic [REG_AW-1:0]               wb_rd,
  input  logic                            wb_side_en,
  input  logic [REG_AW-1:0]               wb_side_rd,
  input  logic                            wb_carry_wr,
  output logic [NUM_OPND-1:0][1:0]        opnd_sel,
  output logic [NUM_OPND-1:0]             opnd_side,
  output logic [1:0]                      cy_sel
);

  localparam logic [REG_AW-1:0] REG_ZERO = '0;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    stage_hit_t near_hit;
    stage_hit_t far_hit;
    opnd_src_e  pick_sel;
    logic       pick_side;

    stage_cmp #(.REG_AW(REG_AW)) i_near_cmp (
      .src     (ex_src[g]),
      .wr_en   (rs_wr_en),
      .rd      (rs_rd),
      .side_en (rs_side_en),
      .side_rd (rs_side_rd),
      .hit     (near_hit)
    );

    stage_cmp #(.REG_AW(REG_AW)) i_far_cmp (
      .src     (ex_src[g]),
      .wr_en   (wb_wr_en),
      .rd      (wb_rd),
      .side_en (wb_side_en),
      .side_rd (wb_side_rd),
      .hit     (far_hit)
    );

    opnd_pick i_pick (
      .near_hit (near_hit),
      .far_hit  (far_hit),
      .sel      (pick_sel),
      .side     (pick_side)
    );

    assign opnd_sel[g]  = pick_sel;
    assign opnd_side[g] = pick_side;

    always_comb begin
      AST_SEL_LEGAL: assert (opnd_sel[g] != 2'b11) else $error("illegal select code"); // R10
      if (opnd_sel[g] == 2'b00)
        AST_SIDE_IDLE: assert (!opnd_side[g]) else $error("side flag without a path"); // R10
      if (ex_src[g] == REG_ZERO)
        AST_ZERO_SRC: assert (opnd_sel[g] == 2'b00 && !opnd_side[g]) else $error("register zero forwarded"); // R5
      if (ex_src[g] != REG_ZERO && rs_wr_en && rs_rd == ex_src[g])
        AST_NEAR_MAIN: assert (opnd_sel[g] == 2'b01 && !opnd_side[g]) else $error("result-stage match lost"); // R2
      if (!rs_wr_en && !rs_side_en && !wb_wr_en && !wb_side_en)
        AST_NO_WRITER: assert (opnd_sel[g] == 2'b00) else $error("path chosen without a writer"); // R6
    end
  end

  opnd_src_e cy_pick;

  carry_pick i_carry (
    .use_carry (ex_use_carry),
    .near_cy   (rs_carry_wr),
    .far_cy    (wb_carry_wr),
    .sel       (cy_pick)
  );

  assign cy_sel = cy_pick;

  always_comb begin
    if (!ex_use_carry)
      AST_CY_QUIET: assert (cy_sel == 2'b00) else $error("carry forwarded while unused"); // R8
    if (ex_use_carry && rs_carry_wr)
      AST_CY_NEAR: assert (cy_sel == 2'b01) else $error("carry not from result stage"); // R8
  end

endmodule

// File: tb/test_operand_fwd_unit.sv
module test_operand_fwd_unit;

  localparam int AW = 5;
  localparam int N  = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [N-1:0][AW-1:0] ex_src;
  logic ex_use_carry;
  logic rs_wr_en, rs_side_en, rs_carry_wr;
  logic [AW-1:0] rs_rd, rs_side_rd;
  logic wb_wr_en, wb_side_en, wb_carry_wr;
  logic [AW-1:0] wb_rd, wb_side_rd;
  logic [N-1:0][1:0] opnd_sel;
  logic [N-1:0] opnd_side;
  logic [1:0] cy_sel;

  operand_fwd_unit #(.REG_AW(AW), .NUM_OPND(N)) i_operand_fwd_unit (
    .ex_src(ex_src), .ex_use_carry(ex_use_carry),
    .rs_wr_en(rs_wr_en), .rs_rd(rs_rd), .rs_side_en(rs_side_en),
    .rs_side_rd(rs_side_rd), .rs_carry_wr(rs_carry_wr),
    .wb_wr_en(wb_wr_en), .wb_rd(wb_rd), .wb_side_en(wb_side_en),
    .wb_side_rd(wb_side_rd), .wb_carry_wr(wb_carry_wr),
    .opnd_sel(opnd_sel), .opnd_side(opnd_side), .cy_sel(cy_sel)
  );

  typedef struct packed {
    logic [1:0] sa; logic da;
    logic [1:0] sb; logic db;
    logic [1:0] cy;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Reference: youngest stage first, named destination before side effect.
  function automatic void ref_opnd(input logic [AW-1:0] s, output logic [1:0] sel, output logic sd);
    sel = 2'b00; sd = 1'b0;
    if (s != 0) begin
      if (rs_wr_en && rs_rd == s)             sel = 2'b01;
      else if (rs_side_en && rs_side_rd == s) begin sel = 2'b01; sd = 1'b1; end
      else if (wb_wr_en && wb_rd == s)        sel = 2'b10;
      else if (wb_side_en && wb_side_rd == s) begin sel = 2'b10; sd = 1'b1; end
    end
  endfunction

  task automatic drive(input logic [AW-1:0] a, input logic [AW-1:0] b, input logic ucy,
                       input logic rwe, input logic [AW-1:0] rrd, input logic rse,
                       input logic [AW-1:0] rsrd, input logic rcy,
                       input logic wwe, input logic [AW-1:0] wrd, input logic wse,
                       input logic [AW-1:0] wsrd, input logic wcy, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    ex_src[0] = a; ex_src[1] = b; ex_use_carry = ucy;
    rs_wr_en = rwe; rs_rd = rrd; rs_side_en = rse; rs_side_rd = rsrd; rs_carry_wr = rcy;
    wb_wr_en = wwe; wb_rd = wrd; wb_side_en = wse; wb_side_rd = wsrd; wb_carry_wr = wcy;
    ref_opnd(a, e.sa, e.da);
    ref_opnd(b, e.sb, e.db);
    e.cy = !ucy ? 2'b00 : rcy ? 2'b01 : wcy ? 2'b10 : 2'b00;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: checks the item driven after the previous rising edge.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if (opnd_sel[0] != e.sa || opnd_side[0] != e.da || opnd_sel[1] != e.sb ||
            opnd_side[1] != e.db || cy_sel != e.cy) begin
          mismatched++;
          $display("FAIL %s: got a=%b/%b b=%b/%b cy=%b expected a=%b/%b b=%b/%b cy=%b",
                   t, opnd_sel[0], opnd_side[0], opnd_sel[1], opnd_side[1], cy_sel,
                   e.sa, e.da, e.sb, e.db, e.cy);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    ex_src = '0; ex_use_carry = 0;
    rs_wr_en = 0; rs_rd = 0; rs_side_en = 0; rs_side_rd = 0; rs_carry_wr = 0;
    wb_wr_en = 0; wb_rd = 0; wb_side_en = 0; wb_side_rd = 0; wb_carry_wr = 0;
    repeat (2) @(posedge clk);
    // R1 idle state and unrelated writers
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    drive(3, 4, 0, 1, 7, 0, 0, 0, 1, 6, 0, 0, 0, "R1");
    // R2 result-stage named destination
    drive(3, 9, 0, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    drive(9, 3, 0, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R3 writeback named destination
    drive(4, 4, 0, 0, 0, 0, 0, 0, 1, 4, 0, 0, 0, "R3");
    // R4 both stages match, result stage wins
    drive(5, 5, 0, 1, 5, 0, 0, 0, 1, 5, 0, 0, 0, "R4");
    drive(5, 6, 0, 0, 1, 1, 5, 0, 1, 5, 0, 0, 0, "R4");
    // R5 register zero
    drive(0, 0, 0, 1, 0, 1, 0, 0, 1, 0, 1, 0, 0, "R5");
    // R6 enables low
    drive(2, 2, 0, 0, 2, 0, 2, 0, 0, 2, 0, 2, 0, "R6");
    drive(2, 1, 0, 0, 2, 0, 0, 0, 1, 1, 0, 2, 0, "R6");
    // R7 side-effect destinations
    drive(6, 0, 0, 0, 0, 1, 6, 0, 0, 0, 0, 0, 0, "R7");
    drive(0, 6, 0, 0, 0, 0, 0, 0, 0, 0, 1, 6, 0, "R7");
    drive(7, 7, 0, 1, 7, 1, 7, 0, 0, 0, 0, 0, 0, "R7");
    drive(7, 1, 0, 0, 0, 0, 0, 0, 1, 7, 1, 7, 0, "R7");
    drive(7, 1, 0, 0, 0, 1, 7, 0, 1, 7, 0, 0, 0, "R7");
    // R8 carry chains
    drive(0, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R8");
    drive(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
    drive(0, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, "R8");
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, "R8");
    drive(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    // R9 operands resolved independently
    drive(3, 4, 0, 1, 3, 0, 0, 0, 1, 4, 0, 0, 0, "R9");
    // R10 side flag without a path
    drive(1, 2, 0, 0, 0, 1, 5, 0, 0, 0, 1, 6, 0, "R10");
    // R9 random streams over a small register pool
    for (int i = 0; i < 400; i++) begin
      drive($urandom_range(0, 7), $urandom_range(0, 7), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), $urandom_range(0, 7), 1'($urandom_range(0, 1)),
            $urandom_range(0, 7), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), $urandom_range(0, 7), 1'($urandom_range(0, 1)),
            $urandom_range(0, 7), 1'($urandom_range(0, 1)), "R9");
    end
    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule